// File: doc/BRIEF.md
# Dual-Width Integer Execution Unit

This block executes one arithmetic instruction per cycle for a compact packet-filter style instruction set. Each instruction arrives as an 8-bit opcode together with the current destination register value, a source register value and a 32-bit immediate. The opcode selects an operation and picks either the 32-bit or the 64-bit class. It also chooses whether the second operand is the source register or the sign-extended immediate. The unit returns a 64-bit result and a write enable for the destination register one cycle later.

The same operation codes serve both classes. In the 32-bit class the operands are cut to their low halves and the result is zero-extended. A byte-order conversion operation reads only the destination register and takes its width from the immediate. Encodings that the unit does not support raise a single fault flag. A faulting instruction writes nothing.

The control is a two-state machine. ST_IDLE means no result is presented. ST_DONE means a result is valid on the outputs. An accepted instruction moves the machine from ST_IDLE to ST_DONE (transition "accept"). Another accepted instruction keeps it in ST_DONE ("chain"). A cycle with no instruction moves ST_DONE back to ST_IDLE ("drain"). ST_IDLE stays put while no instruction arrives ("wait").

Top module: `dwx_exec_unit`

## Requirements
- R1: The opcode is decoded as operation code in bits 7:4, source select in bit 3 and class in bits 2:0. Class 3'd4 is the 32-bit class and class 3'd7 is the 64-bit class. Any other class gives fault=1, wr_en=0, result=0.
- R2: An instruction presented with in_valid=1 at a rising edge drives out_valid=1 with its result, wr_en and fault after that edge. out_valid is 0 after any edge without in_valid. While out_valid is 0, wr_en and fault are 0. Reset clears out_valid, wr_en, fault and result.
- R3: When bit 3 is 1, the second operand is src_val. When bit 3 is 0, it is imm sign-extended to 64 bits.
- R4: In the 32-bit class, both operands are truncated to their low 32 bits and result[63:32] is 0, for every operation except byte-order conversion.
- R5: Operation codes 4'h0 ADD, 4'h1 SUB, 4'h2 MUL (low product bits), 4'h4 OR, 4'h5 AND, 4'hA XOR and 4'hB MOV (second operand) compute at the class width with wr_en=1.
- R6: Code 4'h3 DIV is an unsigned quotient. A zero divisor gives result 0 with fault=0 and wr_en=1.
- R7: Code 4'h9 MOD is an unsigned remainder. A zero divisor returns the destination operand (truncated and zero-extended in the 32-bit class) with fault=0.
- R8: Code 4'h6 is a left shift, 4'h7 a logical right shift and 4'hC an arithmetic right shift that copies bit 31 or bit 63. The shift amount is the second operand masked to 5 bits in the 32-bit class and to 6 bits in the 64-bit class.
- R9: Code 4'h8 NEG returns zero minus the destination operand and ignores the second operand.
- R10: Code 4'hD in the 32-bit class converts byte order on the full dst_val. imm 16, 32 or 64 gives the width. With bit 3 = 0 (to little-endian) the low width bits are kept and the rest cleared. With bit 3 = 1 (to big-endian) the bytes within the width are reversed and the rest cleared.
- R11: Operation codes 4'hE and 4'hF, code 4'hD in the 64-bit class, and code 4'hD with an imm other than 16, 32 or 64 give fault=1, wr_en=0 and result=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Operation code, source select, class |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| out_valid | output | 1 | Result presented this cycle |
| result | output | 64 | Value for the destination register |
| wr_en | output | 1 | Destination register should be written |
| fault | output | 1 | Instruction was not executable |

## Verification
The hardest cases to reach from the ports are where the 32-bit class hides state that a 64-bit view would expose. These include a divisor or shift amount that is zero or in range only after truncation, and a remainder by zero whose destination has live upper bits. The stimulus builds these on purpose. It uses source values whose only set bits are above bit 31, shift amounts of 33 and 65, and destinations with nonzero upper halves. Instructions are issued back to back and with gaps, so the chain and drain transitions are both taken.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int DATA_W = 64;
    localparam int NARROW_W = 32;
    localparam int IMM_W = 32;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL  = 4'h2, OP_DIV  = 4'h3,
        OP_OR   = 4'h4, OP_AND  = 4'h5, OP_LSH  = 4'h6, OP_RSH  = 4'h7,
        OP_NEG  = 4'h8, OP_MOD  = 4'h9, OP_XOR  = 4'hA, OP_MOV  = 4'hB,
        OP_ARSH = 4'hC, OP_END  = 4'hD, OP_RSVE = 4'hE, OP_RSVF = 4'hF
    } exu_op_e;

    localparam logic [2:0] CLS_NARROW = 3'd4;
    localparam logic [2:0] CLS_WIDE   = 3'd7;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } exu_state_e;
endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel #(
    parameter int DW = exu_pkg::DATA_W,
    parameter int NW = exu_pkg::NARROW_W,
    parameter int IW = exu_pkg::IMM_W
) (
    input  logic [DW-1:0] dst_val,
    input  logic [DW-1:0] src_val,
    input  logic [IW-1:0] imm,
    input  logic          use_reg,
    input  logic          narrow,
    output logic [DW-1:0] op_a,
    output logic [DW-1:0] op_b
);
    logic [DW-1:0] imm_ext;
    logic [DW-1:0] b_raw;

    always_comb begin
        imm_ext = {{(DW-IW){imm[IW-1]}}, imm};
        b_raw   = use_reg ? src_val : imm_ext;
        if (narrow) begin
            op_a = {{(DW-NW){1'b0}}, dst_val[NW-1:0]};
            op_b = {{(DW-NW){1'b0}}, b_raw[NW-1:0]};
        end else begin
            op_a = dst_val;
            op_b = b_raw;
        end
    end
endmodule

// File: rtl/exu_byte_order.sv
module exu_byte_order #(
    parameter int DW = exu_pkg::DATA_W
) (
    input  logic [DW-1:0] din,
    input  logic [1:0]    wsel,
    input  logic          to_big,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    logic [DW-1:0] rev_full, rev_half, rev_qtr;
    logic [DW-1:0] keep_mask;

    for (genvar g = 0; g < NB; g++) begin : g_full
        assign rev_full[8*g +: 8] = din[8*(NB-1-g) +: 8];
    end
    for (genvar g = 0; g < NB/2; g++) begin : g_half
        assign rev_half[8*g +: 8] = din[8*(NB/2-1-g) +: 8];
    end
    assign rev_half[DW-1:DW/2] = '0;
    for (genvar g = 0; g < NB/4; g++) begin : g_qtr
        assign rev_qtr[8*g +: 8] = din[8*(NB/4-1-g) +: 8];
    end
    assign rev_qtr[DW-1:DW/4] = '0;

    always_comb begin
        unique case (wsel)
            2'd0:    keep_mask = {{(DW-DW/4){1'b0}}, {(DW/4){1'b1}}};
            2'd1:    keep_mask = {{(DW-DW/2){1'b0}}, {(DW/2){1'b1}}};
            default: keep_mask = '1;
        endcase
        if (!to_big) begin
            dout = din & keep_mask;
        end else begin
            unique case (wsel)
                2'd0:    dout = rev_qtr;
                2'd1:    dout = rev_half;
                default: dout = rev_full;
            endcase
        end
    end
endmodule

// File: rtl/exu_arith.sv
module exu_arith
    import exu_pkg::*;
#(
    parameter int DW = exu_pkg::DATA_W,
    parameter int NW = exu_pkg::NARROW_W
) (
    input  exu_op_e       op,
    input  logic          narrow,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] res
);
    localparam int SHW = $clog2(DW);

    logic [SHW-1:0]        sh;
    logic signed [NW-1:0]  a_nar_s;
    logic signed [NW-1:0]  ars_nar;
    logic signed [DW-1:0]  a_wide_s;
    logic signed [DW-1:0]  ars_wide;
    logic [DW-1:0]         raw;

    always_comb begin
        sh       = narrow ? {1'b0, op_b[SHW-2:0]} : op_b[SHW-1:0];
        a_nar_s  = op_a[NW-1:0];
        a_wide_s = op_a;
        ars_nar  = a_nar_s >>> sh;
        ars_wide = a_wide_s >>> sh;
        unique case (op)
            OP_ADD:  raw = op_a + op_b;
            OP_SUB:  raw = op_a - op_b;
            OP_MUL:  raw = op_a * op_b;
            OP_DIV:  raw = (op_b == '0) ? '0 : op_a / op_b;
            OP_OR:   raw = op_a | op_b;
            OP_AND:  raw = op_a & op_b;
            OP_LSH:  raw = op_a << sh;
            OP_RSH:  raw = op_a >> sh;
            OP_NEG:  raw = '0 - op_a;
            OP_MOD:  raw = (op_b == '0) ? op_a : op_a % op_b;
            OP_XOR:  raw = op_a ^ op_b;
            OP_MOV:  raw = op_b;
            OP_ARSH: raw = narrow ? {{(DW-NW){1'b0}}, ars_nar} : ars_wide;
            default: raw = '0;
        endcase
        res = narrow ? {{(DW-NW){1'b0}}, raw[NW-1:0]} : raw;
    end
endmodule

// File: rtl/dwx_exec_unit.sv
module dwx_exec_unit
    import exu_pkg::*;
#(
    parameter int DW = exu_pkg::DATA_W,
    parameter int NW = exu_pkg::NARROW_W,
    parameter int IW = exu_pkg::IMM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    opcode,
    input  logic [DW-1:0] dst_val,
    input  logic [DW-1:0] src_val,
    input  logic [IW-1:0] imm,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          wr_en,
    output logic          fault
);
    exu_state_e    state_q, state_d;
    exu_op_e       op;
    logic [2:0]    cls;
    logic          narrow, cls_ok, is_end, width_ok, bad;
    logic [1:0]    wsel;
    logic [DW-1:0] op_a, op_b, arith_res, swap_res, next_res;

    always_comb begin
        op       = exu_op_e'(opcode[7:4]);
        cls      = opcode[2:0];
        narrow   = (cls == CLS_NARROW);
        cls_ok   = narrow || (cls == CLS_WIDE);
        is_end   = (op == OP_END);
        width_ok = 1'b1;
        wsel     = 2'd2;
        unique case (imm)
            IW'(DW/4): wsel = 2'd0;
            IW'(DW/2): wsel = 2'd1;
            IW'(DW):   wsel = 2'd2;
            default:   width_ok = 1'b0;
        endcase
        bad = !cls_ok || (op == OP_RSVE) || (op == OP_RSVF)
              || (is_end && (!narrow || !width_ok));
    end

    exu_operand_sel #(.DW(DW), .NW(NW), .IW(IW)) u_opsel (
        .dst_val (dst_val),
        .src_val (src_val),
        .imm     (imm),
        .use_reg (opcode[3]),
        .narrow  (narrow),
        .op_a    (op_a),
        .op_b    (op_b)
    );

    exu_arith #(.DW(DW), .NW(NW)) u_arith (
        .op     (op),
        .narrow (narrow),
        .op_a   (op_a),
        .op_b   (op_b),
        .res    (arith_res)
    );

    exu_byte_order #(.DW(DW)) u_border (
        .din    (dst_val),
        .wsel   (wsel),
        .to_big (opcode[3]),
        .dout   (swap_res)
    );

    always_comb begin
        if (bad)         next_res = '0;
        else if (is_end) next_res = swap_res;
        else             next_res = arith_res;
    end

    // next-state logic: accept / chain / drain / wait
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            wr_en  <= 1'b0;
            fault  <= 1'b0;
        end else if (in_valid) begin
            result <= next_res;
            wr_en  <= !bad;
            fault  <= bad;
        end else begin
            result <= '0;
            wr_en  <= 1'b0;
            fault  <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_DONE);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && !fault));
    a_r11_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!wr_en && result == '0));
    a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && narrow && !is_end && !bad) |=> (result[DW-1:NW] == '0));
    a_r6_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls_ok && op == OP_DIV && op_b == '0) |=> (result == '0 && wr_en));
    a_r7_mod_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls_ok && op == OP_MOD && op_b == '0) |=> (result == $past(op_a) && !fault));
endmodule

// File: tb/tb_dwx_exec_unit.sv
module tb_dwx_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [63:0] dst_val = '0, src_val = '0;
    logic [31:0] imm = '0;
    logic        out_valid, wr_en, fault;
    logic [63:0] result;

    int tests = 0;
    int fails = 0;
    bit reported = 0;

    typedef struct {
        logic [63:0] res;
        logic        we;
        logic        flt;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    dwx_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm),
        .out_valid(out_valid), .result(result), .wr_en(wr_en), .fault(fault)
    );

    function automatic void model(input logic [7:0] oc, input logic [63:0] d,
                                  input logic [63:0] s, input logic [31:0] im,
                                  output logic [63:0] r, output logic f);
        logic [3:0]  code;
        logic        w32, ok;
        logic [63:0] k, x, y;
        int          n;
        logic signed [31:0] t32;
        logic signed [63:0] t64;
        code = oc[7:4];
        w32  = (oc[2:0] == 3'd4);
        ok   = w32 || (oc[2:0] == 3'd7);
        k    = oc[3] ? s : {{32{im[31]}}, im};
        x    = w32 ? {32'h0, d[31:0]} : d;
        y    = w32 ? {32'h0, k[31:0]} : k;
        n    = w32 ? int'(y[4:0]) : int'(y[5:0]);
        f = 1'b0;
        r = '0;
        if (!ok) f = 1'b1;
        else begin
            case (code)
                4'h0: r = x + y;
                4'h1: r = x - y;
                4'h2: r = x * y;
                4'h3: r = (y == 0) ? 64'h0 : x / y;
                4'h4: r = x | y;
                4'h5: r = x & y;
                4'h6: r = x << n;
                4'h7: r = x >> n;
                4'h8: r = 64'h0 - x;
                4'h9: r = (y == 0) ? x : x % y;
                4'hA: r = x ^ y;
                4'hB: r = y;
                4'hC: begin
                    if (w32) begin t32 = x[31:0]; t32 = t32 >>> n; r = {32'h0, t32}; end
                    else begin t64 = x; t64 = t64 >>> n; r = t64; end
                end
                4'hD: begin
                    if (!w32) f = 1'b1;
                    else if (im == 16) r = oc[3] ? {48'h0, d[7:0], d[15:8]} : {48'h0, d[15:0]};
                    else if (im == 32) r = oc[3] ? {32'h0, d[7:0], d[15:8], d[23:16], d[31:24]}
                                                 : {32'h0, d[31:0]};
                    else if (im == 64) r = oc[3] ? {d[7:0], d[15:8], d[23:16], d[31:24],
                                                    d[39:32], d[47:40], d[55:48], d[63:56]} : d;
                    else f = 1'b1;
                end
                default: f = 1'b1;
            endcase
            if (w32 && code != 4'hD) r[63:32] = 32'h0;
        end
        if (f) r = '0;
    endfunction

    task automatic issue(input string tag, input logic [7:0] oc, input logic [63:0] d,
                         input logic [63:0] s, input logic [31:0] im, input int gap);
        exp_t e;
        logic [63:0] r;
        logic f;
        model(oc, d, s, im, r, f);
        e.res = r; e.we = !f; e.flt = f; e.tag = tag;
        @(negedge clk);
        opcode = oc; dst_val = d; src_val = s; imm = im; in_valid = 1'b1;
        sb.push_back(e);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && out_valid) begin
                tests++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (result !== e.res || wr_en !== e.we || fault !== e.flt) begin
                        fails++;
                        $display("FAIL %s: actual res=%h we=%b flt=%b expected res=%h we=%b flt=%b",
                                 e.tag, result, wr_en, fault, e.res, e.we, e.flt);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || fault !== 1'b0 || result !== 64'h0) begin
            fails++;
            $display("FAIL R2 reset: actual v=%b we=%b f=%b res=%h expected 0", out_valid, wr_en, fault, result);
        end
        rst_n = 1'b1;

        // R5 R3 basic and wrap cases, back to back (chain)
        issue("R5 add64 wrap",    8'h0F, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 0);
        issue("R4 add32 trunc",   8'h0C, 64'h1_FFFF_FFFF, 64'h1, 32'h0, 0);
        issue("R3 add64 imm -1",  8'h07, 64'h5, 64'h0, 32'hFFFF_FFFF, 0);
        issue("R3 sub32 imm",     8'h14, 64'hAB_0000_0010, 64'h0, 32'h0000_0020, 0);
        issue("R5 mul64",         8'h2F, 64'h1_0000_0003, 64'h7, 32'h0, 0);
        issue("R4 mul32",         8'h2C, 64'hFFFF_0001_0000, 64'h1_0000, 32'h0, 0);
        issue("R5 or64",          8'h4F, 64'hF0F0, 64'h0F0F_0000_0000_0000, 32'h0, 0);
        issue("R5 and32",         8'h5C, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 32'h0, 0);
        issue("R5 xor64 imm",     8'hA7, 64'h0, 64'h0, 32'h8000_0001, 0);
        issue("R5 mov32 imm",     8'hB4, 64'hDEAD_BEEF_0000_0000, 64'h0, 32'hFFFF_FF80, 0);
        issue("R5 mov64 imm",     8'hB7, 64'h0, 64'h0, 32'hFFFF_FF80, 2);
        // R6 / R7
        issue("R6 div64",         8'h3F, 64'd100, 64'd7, 32'h0, 0);
        issue("R6 div64 zero",    8'h3F, 64'd100, 64'd0, 32'h0, 0);
        issue("R6 div32 hidden zero", 8'h3C, 64'd100, 64'h1_0000_0000, 32'h0, 0);
        issue("R7 mod64",         8'h9F, 64'd100, 64'd7, 32'h0, 0);
        issue("R7 mod64 zero",    8'h9F, 64'hCAFE_0000_0000_0042, 64'd0, 32'h0, 0);
        issue("R7 mod32 zero",    8'h9C, 64'hCAFE_0000_0000_0042, 64'h2_0000_0000, 32'h0, 3);
        // R8 shifts
        issue("R8 lsh32 mask",    8'h6C, 64'h8000_0001, 64'd33, 32'h0, 0);
        issue("R8 lsh64 mask",    8'h6F, 64'h8000_0001, 64'd65, 32'h0, 0);
        issue("R8 rsh64 logical", 8'h7F, 64'h8000_0000_0000_0000, 64'd4, 32'h0, 0);
        issue("R8 rsh32 imm",     8'h74, 64'hFFFF_FFFF_8000_0000, 64'h0, 32'd4, 0);
        issue("R8 arsh64",        8'hCF, 64'h8000_0000_0000_0000, 64'd4, 32'h0, 0);
        issue("R8 arsh32",        8'hCC, 64'h8000_0000, 64'd36, 32'h0, 0);
        // R9
        issue("R9 neg64",         8'h8F, 64'd5, 64'h1234, 32'h0, 0);
        issue("R9 neg32",         8'h84, 64'd5, 64'h0, 32'h7, 1);
        // R10 byte order
        issue("R10 le16",         8'hD4, 64'h1122_3344_5566_7788, 64'h0, 32'd16, 0);
        issue("R10 le32",         8'hD4, 64'h1122_3344_5566_7788, 64'h0, 32'd32, 0);
        issue("R10 le64",         8'hD4, 64'h1122_3344_5566_7788, 64'h0, 32'd64, 0);
        issue("R10 be16",         8'hDC, 64'h1122_3344_5566_7788, 64'h0, 32'd16, 0);
        issue("R10 be32",         8'hDC, 64'h1122_3344_5566_7788, 64'h0, 32'd32, 0);
        issue("R10 be64",         8'hDC, 64'h1122_3344_5566_7788, 64'h0, 32'd64, 0);
        // R11 and R1 faults
        issue("R11 end bad width", 8'hDC, 64'h1122_3344_5566_7788, 64'h0, 32'd8, 0);
        issue("R11 end wide class", 8'hD7, 64'h1122_3344_5566_7788, 64'h0, 32'd16, 0);
        issue("R11 code E",       8'hEF, 64'h1, 64'h2, 32'h0, 0);
        issue("R1 bad class 5",   8'h0D, 64'h1, 64'h2, 32'h0, 0);
        issue("R1 bad class 0",   8'h00, 64'h1, 64'h2, 32'h0, 1);

        // R2: after the gap, no result must be presented
        @(negedge clk);
        #1;
        tests++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || fault !== 1'b0) begin
            fails++;
            $display("FAIL R2 drain: actual v=%b we=%b f=%b expected 0 0 0", out_valid, wr_en, fault);
        end
        for (int i = 0; i < 20 && sb.size() != 0; i++) @(negedge clk);
        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2 missing results: actual %0d pending expected 0", sb.size());
        end
        finish_run();
    end
endmodule